// File: doc/BRIEF.md
# Interruptible Write Burst Sequencer

This block turns write commands for a double-data-rate SDRAM into the per-beat stream that the data path consumes. Each command names a bank, a starting column, four data words and four mask bits. Every burst is four beats long. Each clock carries two beats: lane 0 is the rising-edge phase and lane 1 is the falling-edge phase. Each beat comes with a valid flag, bank, column, data word and mask bit.

The write latency is one clock. A command sampled on one edge delivers beats 0 and 1 in the clock that follows, and beats 2 and 3 in the clock after that. A new command may arrive on any edge, to any bank. If it arrives while the second half of a burst is still pending, that half is dropped and a complete fresh burst starts at the new address. A burst issued with auto-precharge cannot be cut off this way. A command that tries is discarded, the error flag rises for one clock, and the protected burst finishes.

The controller has three states. `ST_IDLE` emits nothing. `ST_HEAD` emits beats 0 and 1. `ST_TAIL` emits beats 2 and 3. An accepted command moves any state to `ST_HEAD`. Without an accepted command, `ST_HEAD` moves to `ST_TAIL`, and `ST_TAIL` and `ST_IDLE` move to `ST_IDLE`. A command is rejected only in `ST_HEAD` while the held burst carries auto-precharge.

Top module: `wr_burst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, both beat_vld bits and err_illegal are 0.
- R2: A command sampled on edge k is accepted unless R7 applies. Beats 0 and 1 then appear on lanes 0 and 1 in the cycle after edge k. Beats 2 and 3 appear on lanes 0 and 1 in the next cycle, unless R5 applies. Both lanes are always valid together.
- R3: Every beat of a burst carries the command's bank. Beat i carries the column whose bits above bit 1 match the starting column and whose two low bits are (start[1:0] + i) mod 4, so the column wraps inside the aligned group of four.
- R4: Beat i carries data bits [i*DQ_W +: DQ_W] of cmd_data and bit i of cmd_mask.
- R5: A command accepted on the edge that would start a burst's second half cancels beats 2 and 3 of that burst. The new burst's beats 0 and 1 follow in the next cycle, whatever the bank. This holds for commands on every consecutive edge.
- R6: A command accepted on the edge after a burst's second half has been emitted starts its beats in the next cycle, with no idle gap between the bursts.
- R7: A command sampled while beats 2 and 3 of an auto-precharge burst are still pending is discarded. err_illegal is 1 for exactly the next cycle, and the protected burst emits beats 2 and 3 unchanged.
- R8: A command sampled during an auto-precharge burst's second-half cycle is accepted as in R6.
- R9: When no burst is being emitted, both beat_vld bits are 0. err_illegal is 0 in every cycle except the one named in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Write command present this cycle |
| cmd_ap | input | 1 | Command requests auto-precharge |
| cmd_bank | input | BANK_W | Target bank |
| cmd_col | input | COL_W | Starting column |
| cmd_data | input | 4*DQ_W | Four data words; word i at bits [i*DQ_W +: DQ_W] |
| cmd_mask | input | 4 | Mask bit i belongs to word i |
| beat_vld | output | 2 | Valid per lane (bit 0 rising phase, bit 1 falling phase) |
| beat_bank | output | 2*BANK_W | Bank per lane |
| beat_col | output | 2*COL_W | Column per lane |
| beat_data | output | 2*DQ_W | Data word per lane |
| beat_mask | output | 2 | Mask bit per lane |
| err_illegal | output | 1 | One-cycle pulse when a command is discarded under R7 |

## Verification
The bench builds the block with BANK_W=2, COL_W=5 and DQ_W=8. The narrow column width puts the top of the column space within reach, so a burst starting at column 30 can show its wrap back to 28 and 29 inside the highest aligned group. The 8-bit data width keeps each beat's data word distinct, which makes a misplaced or dropped beat visible. With four banks, the interrupting commands can target banks other than the interrupted one.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    // Burst geometry: four beats, two per clock.
    localparam int BURST_LEN = 4;
    localparam int LANES     = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } wbs_state_e;

endpackage

// File: rtl/wbs_ctrl.sv
module wbs_ctrl
    import wbs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  logic                        cmd_ap,
    input  logic [BANK_W-1:0]           cmd_bank,
    input  logic [COL_W-1:0]            cmd_col,
    input  logic [BURST_LEN*DQ_W-1:0]   cmd_data,
    input  logic [BURST_LEN-1:0]        cmd_mask,
    output wbs_state_e                  state_o,
    output logic [BANK_W-1:0]           bank_o,
    output logic [COL_W-1:0]            col_o,
    output logic [BURST_LEN*DQ_W-1:0]   data_o,
    output logic [BURST_LEN-1:0]        mask_o,
    output logic                        err_o
);

    wbs_state_e state_q, state_d;
    logic       ap_q;
    logic       reject;
    logic       take;

    // Next state: accept unless the held burst is protected and still has beats pending.
    always_comb begin
        reject  = cmd_valid && (state_q == ST_HEAD) && ap_q;
        take    = cmd_valid && !reject;
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_HEAD : ST_IDLE;
            ST_HEAD: state_d = take ? ST_HEAD : ST_TAIL;
            ST_TAIL: state_d = take ? ST_HEAD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Command capture and error pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_o <= '0;
            col_o  <= '0;
            data_o <= '0;
            mask_o <= '0;
            ap_q   <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            err_o <= reject;
            if (take) begin
                bank_o <= cmd_bank;
                col_o  <= cmd_col;
                data_o <= cmd_data;
                mask_o <= cmd_mask;
                ap_q   <= cmd_ap;
            end
        end
    end

    assign state_o = state_q;

    // R2
    accept_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !(state_q == ST_HEAD && ap_q)) |=>
        (state_q == ST_HEAD && col_o == $past(cmd_col) && bank_o == $past(cmd_bank)));

    // R2
    tail_once_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL) |=> (state_q != ST_TAIL));

    // R7
    ap_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HEAD && ap_q && cmd_valid) |=>
        (err_o && state_q == ST_TAIL && $stable(col_o) && $stable(bank_o)));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($past(cmd_valid) && $past(state_q) == ST_HEAD));

endmodule

// File: rtl/wbs_lane.sv
module wbs_lane
    import wbs_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16
) (
    input  wbs_state_e                  state_i,
    input  logic [BANK_W-1:0]           bank_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [BURST_LEN*DQ_W-1:0]   data_i,
    input  logic [BURST_LEN-1:0]        mask_i,
    output logic                        vld_o,
    output logic [BANK_W-1:0]           bank_o,
    output logic [COL_W-1:0]            col_o,
    output logic [DQ_W-1:0]             data_o,
    output logic                        mask_o
);

    localparam logic [1:0] HEAD_IDX = 2'(LANE);
    localparam logic [1:0] TAIL_IDX = 2'(LANES + LANE);

    logic [1:0] idx;
    logic [1:0] low;

    // Output process: pick this lane's beat of the current half.
    always_comb begin
        idx = HEAD_IDX;
        unique case (state_i)
            ST_IDLE: idx = HEAD_IDX;
            ST_HEAD: idx = HEAD_IDX;
            ST_TAIL: idx = TAIL_IDX;
            default: idx = HEAD_IDX;
        endcase
        low    = col_i[1:0] + idx;
        vld_o  = (state_i == ST_HEAD) || (state_i == ST_TAIL);
        bank_o = vld_o ? bank_i : '0;
        col_o  = vld_o ? {col_i[COL_W-1:2], low} : '0;
        data_o = vld_o ? data_i[int'(idx)*DQ_W +: DQ_W] : '0;
        mask_o = vld_o ? mask_i[idx] : 1'b0;
    end

endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq
    import wbs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic                      cmd_ap,
    input  logic [BANK_W-1:0]         cmd_bank,
    input  logic [COL_W-1:0]          cmd_col,
    input  logic [4*DQ_W-1:0]         cmd_data,
    input  logic [3:0]                cmd_mask,
    output logic [1:0]                beat_vld,
    output logic [2*BANK_W-1:0]       beat_bank,
    output logic [2*COL_W-1:0]        beat_col,
    output logic [2*DQ_W-1:0]         beat_data,
    output logic [1:0]                beat_mask,
    output logic                      err_illegal
);

    wbs_state_e                  state;
    logic [BANK_W-1:0]           cur_bank;
    logic [COL_W-1:0]            cur_col;
    logic [BURST_LEN*DQ_W-1:0]   cur_data;
    logic [BURST_LEN-1:0]        cur_mask;

    wbs_ctrl #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ap    (cmd_ap),
        .cmd_bank  (cmd_bank),
        .cmd_col   (cmd_col),
        .cmd_data  (cmd_data),
        .cmd_mask  (cmd_mask),
        .state_o   (state),
        .bank_o    (cur_bank),
        .col_o     (cur_col),
        .data_o    (cur_data),
        .mask_o    (cur_mask),
        .err_o     (err_illegal)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wbs_lane #(.LANE(l), .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_lane (
            .state_i (state),
            .bank_i  (cur_bank),
            .col_i   (cur_col),
            .data_i  (cur_data),
            .mask_i  (cur_mask),
            .vld_o   (beat_vld[l]),
            .bank_o  (beat_bank[l*BANK_W +: BANK_W]),
            .col_o   (beat_col[l*COL_W +: COL_W]),
            .data_o  (beat_data[l*DQ_W +: DQ_W]),
            .mask_o  (beat_mask[l])
        );
    end

    // R2
    lanes_paired_chk: assert property (@(posedge clk) disable iff (rst)
        beat_vld[0] == beat_vld[1]);

    // R3
    lane_col_step_chk: assert property (@(posedge clk) disable iff (rst)
        beat_vld[1] |-> (beat_col[COL_W +: 2] == beat_col[1:0] + 2'd1 &&
                         beat_col[2*COL_W-1:COL_W+2] == beat_col[COL_W-1:2] &&
                         beat_bank[BANK_W +: BANK_W] == beat_bank[BANK_W-1:0]));

endmodule

// File: tb/tb_wr_burst_seq.sv
module tb_wr_burst_seq;

    localparam int BANK_W = 2;
    localparam int COL_W  = 5;
    localparam int DQ_W   = 8;
    localparam int CLK_PERIOD = 10;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cmd_valid = 1'b0;
    logic                  cmd_ap = 1'b0;
    logic [BANK_W-1:0]     cmd_bank = '0;
    logic [COL_W-1:0]      cmd_col = '0;
    logic [4*DQ_W-1:0]     cmd_data = '0;
    logic [3:0]            cmd_mask = '0;
    logic [1:0]            beat_vld;
    logic [2*BANK_W-1:0]   beat_bank;
    logic [2*COL_W-1:0]    beat_col;
    logic [2*DQ_W-1:0]     beat_data;
    logic [1:0]            beat_mask;
    logic                  err_illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ap(cmd_ap),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
        .beat_vld(beat_vld), .beat_bank(beat_bank), .beat_col(beat_col),
        .beat_data(beat_data), .beat_mask(beat_mask), .err_illegal(err_illegal)
    );

    // Scoreboard queues, one entry per clock.
    logic [1:0]          q_vld[$];
    logic [2*BANK_W-1:0] q_bank[$];
    logic [2*COL_W-1:0]  q_col[$];
    logic [2*DQ_W-1:0]   q_data[$];
    logic [1:0]          q_mask[$];
    logic                q_err[$];
    string               q_tag[$];

    // Reference burst held by the bench model.
    int                m_phase = 0;
    logic              m_ap = 1'b0;
    logic [BANK_W-1:0] m_bank = '0;
    logic [COL_W-1:0]  m_col = '0;
    logic [4*DQ_W-1:0] m_data = '0;
    logic [3:0]        m_mask = '0;
    logic              m_ill;
    string             m_tag;

    task automatic check(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cycles);
        end
    endtask

    function automatic logic [4*DQ_W-1:0] mkdata(input int seed);
        logic [4*DQ_W-1:0] d;
        for (int i = 0; i < 4; i++) d[i*DQ_W +: DQ_W] = DQ_W'(seed * 16 + i + 1);
        return d;
    endfunction

    task automatic push_beats(input int base, input string tag);
        logic [2*BANK_W-1:0] b;
        logic [2*COL_W-1:0]  c;
        logic [2*DQ_W-1:0]   d;
        logic [1:0]          mk;
        for (int l = 0; l < 2; l++) begin
            logic [1:0] lo;
            lo = m_col[1:0] + 2'(base + l);
            b[l*BANK_W +: BANK_W] = m_bank;
            c[l*COL_W +: COL_W]   = {m_col[COL_W-1:2], lo};
            d[l*DQ_W +: DQ_W]     = m_data[(base + l)*DQ_W +: DQ_W];
            mk[l]                 = m_mask[base + l];
        end
        q_vld.push_back(2'b11); q_bank.push_back(b); q_col.push_back(c);
        q_data.push_back(d); q_mask.push_back(mk); q_tag.push_back(tag);
    endtask

    // Reference model: expected output for the cycle after each edge.
    always @(posedge clk) begin
        if (!rst) begin
            m_ill = cmd_valid && (m_phase == 1) && m_ap;
            if (cmd_valid && !m_ill) begin
                if (m_phase == 0)      m_tag = "R2";
                else if (m_phase == 1) m_tag = "R5";
                else                   m_tag = m_ap ? "R8" : "R6";
                m_bank = cmd_bank; m_col = cmd_col; m_data = cmd_data;
                m_mask = cmd_mask; m_ap = cmd_ap; m_phase = 1;
                push_beats(0, m_tag);
            end else if (m_phase == 1) begin
                m_phase = 2;
                push_beats(2, m_ill ? "R7" : "R2");
            end else begin
                m_phase = 0;
                q_vld.push_back(2'b00); q_bank.push_back('0); q_col.push_back('0);
                q_data.push_back('0); q_mask.push_back(2'b00); q_tag.push_back("R9");
            end
            q_err.push_back(m_ill);
        end
    end

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (q_vld.size() > 0) begin
            logic [1:0] ev; logic [2*BANK_W-1:0] eb; logic [2*COL_W-1:0] ec;
            logic [2*DQ_W-1:0] ed; logic [1:0] em; logic ee; string t;
            ev = q_vld.pop_front(); eb = q_bank.pop_front(); ec = q_col.pop_front();
            ed = q_data.pop_front(); em = q_mask.pop_front(); ee = q_err.pop_front();
            t = q_tag.pop_front();
            check(beat_vld == ev, t, 64'(beat_vld), 64'(ev));
            check(err_illegal == ee, ee ? "R7" : "R9", 64'(err_illegal), 64'(ee));
            if (ev != 2'b00) begin
                check(beat_bank == eb && beat_col == ec, {t, " R3 bank/col"},
                      64'({beat_bank, beat_col}), 64'({eb, ec}));
                check(beat_data == ed && beat_mask == em, {t, " R4 data/mask"},
                      64'({beat_data, beat_mask}), 64'({ed, em}));
            end
        end
    end

    task automatic issue(input int bk, input int col, input int seed, input logic ap);
        cmd_valid = 1'b1; cmd_ap = ap;
        cmd_bank = BANK_W'(bk); cmd_col = COL_W'(col);
        cmd_data = mkdata(seed); cmd_mask = 4'(seed * 5 + 3);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_ap = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R1: outputs quiet during reset
        check(beat_vld == 2'b00 && err_illegal == 1'b0, "R1",
              64'({beat_vld, err_illegal}), 64'd0);
        rst = 1'b0;
        idle(2);
        // R2, R3, R4: single burst
        issue(1, 4, 1, 1'b0);      idle(3);
        // R3: column wraps inside the top aligned group (30,31,28,29)
        issue(2, 30, 2, 1'b0);     idle(3);
        // R5: interrupt to another bank
        issue(0, 8, 3, 1'b0);
        issue(3, 17, 4, 1'b0);     idle(3);
        // R5: commands on four consecutive edges
        issue(1, 1, 5, 1'b0);
        issue(2, 6, 6, 1'b0);
        issue(3, 11, 7, 1'b0);
        issue(0, 23, 8, 1'b0);     idle(3);
        // R6: command during second half, no gap
        issue(1, 12, 9, 1'b0);     idle(1);
        issue(2, 13, 10, 1'b0);    idle(3);
        // R7: interrupt of an auto-precharge burst is discarded
        issue(3, 20, 11, 1'b1);
        issue(0, 2, 12, 1'b0);     idle(3);
        // R8: command on the protected burst's second-half cycle is accepted
        issue(2, 27, 13, 1'b1);    idle(1);
        issue(1, 9, 14, 1'b0);     idle(4);
        // R9: queue drained, nothing left outstanding
        check(q_vld.size() <= 1, "R9", 64'(q_vld.size()), 64'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule